// File: doc/BRIEF.md
# Dual-Source Serial Baud Tick Generator

This block supplies a serial port with two single-cycle strobes, one pacing the transmitter and one pacing the receiver. Each strobe runs at sixteen times the bit rate. The strobes come from timer overflows. Two auto-reload timers run side by side.

The narrow timer counts either on every clock or on every twelfth clock. Its overflows can pass straight through, or only every second one can pass, depending on a rate doubler bit. The wide timer counts on every second clock, and only while at least one channel selects it. Its overflows pass straight through.

Each timer restarts from its reload input when it rolls over. A reload value presented mid-count is picked up at the following rollover. Two select bits route either source to the TX and RX strobes independently.

Top module: `baud_tick_gen`

## Requirements
- R1: A synchronous reset drives both ticks low and clears both counters and all prescale state. With the narrow timer stepping on every clock, the first narrow overflow tick then appears on the 256th clock after reset is released.
- R2: With `narrowFast`=1 and `doubleRate`=1, a channel whose select is 0 ticks once every 256−`narrowReload` clocks.
- R3: With `doubleRate`=0, only every second narrow overflow yields a tick, so the period is 2×(256−`narrowReload`) clocks.
- R4: With `narrowFast`=0, the narrow timer steps once per 12 clocks, so both narrow periods grow twelvefold.
- R5: A channel whose select is 1 ticks once every 2×(2^WIDE_W−`wideReload`) clocks.
- R6: `txUseWide` and `rxUseWide` act independently, so TX and RX may run from different sources at different rates at the same time.
- R7: While both selects are 0, the wide counter holds its value. After a channel selects it, the first wide tick needs a full 2^WIDE_W steps from a cleared counter.
- R8: A change of `narrowReload` leaves the interval in progress unchanged and sets the length of the interval after the next rollover.
- R9: Each tick is high for exactly one clock whenever its period exceeds one clock.
- R10: When both selects are equal, `txTick` and `rxTick` are identical in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| narrowFast | input | 1 | 1: narrow timer steps every clock; 0: every 12th clock |
| doubleRate | input | 1 | 1: every narrow overflow ticks; 0: every second one |
| txUseWide | input | 1 | TX source: 1 wide timer, 0 narrow timer |
| rxUseWide | input | 1 | RX source: 1 wide timer, 0 narrow timer |
| narrowReload | input | NARROW_W | Narrow timer reload value |
| wideReload | input | WIDE_W | Wide timer reload value |
| txTick | output | 1 | TX 16x baud strobe |
| rxTick | output | 1 | RX 16x baud strobe |

## Verification
Several functions can fall in the same cycle here. A narrow overflow and a wide overflow may coincide while the two channels are routed to different sources. A reload change may also land while a count is in progress.

The bench provokes the first case with mixed selects, and the same-source case with equal selects. In both it compares the recorded times of the TX and RX ticks. It provokes the second case by changing the narrow reload just after a rollover. It then checks that the running interval keeps the old length and the next one takes the new length.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  // per-cycle count enables issued by control to the datapath
  typedef struct packed {
    logic narrowStep;
    logic wideStep;
  } step_t;

  // rollover strobes returned by the datapath
  typedef struct packed {
    logic narrowWrap;
    logic wideWrap;
  } wrap_t;

  localparam int unsigned CH_TX = 0;
  localparam int unsigned CH_RX = 1;
  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/baud_reload_ctr.sv
module baud_reload_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] reloadVal,
  output logic [W-1:0] count,
  output logic         wrap
);
  logic atTop;
  assign atTop = (count == {W{1'b1}});
  assign wrap  = step && atTop;

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (step)
      count <= atTop ? reloadVal : count + 1'b1;
  end
endmodule

// File: rtl/baud_tick_dp.sv
module baud_tick_dp
  import baud_tick_pkg::*;
#(
  parameter int unsigned NARROW_W = 8,
  parameter int unsigned WIDE_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  step_t               step,
  input  logic [NARROW_W-1:0] narrowReload,
  input  logic [WIDE_W-1:0]   wideReload,
  output wrap_t               wrap,
  output logic [NARROW_W-1:0] narrowCount,
  output logic [WIDE_W-1:0]   wideCount
);
  logic narrowWrap, wideWrap;

  baud_reload_ctr #(.W(NARROW_W)) u_narrow (
    .clk(clk), .rst(rst), .step(step.narrowStep),
    .reloadVal(narrowReload), .count(narrowCount), .wrap(narrowWrap)
  );

  baud_reload_ctr #(.W(WIDE_W)) u_wide (
    .clk(clk), .rst(rst), .step(step.wideStep),
    .reloadVal(wideReload), .count(wideCount), .wrap(wideWrap)
  );

  assign wrap.narrowWrap = narrowWrap;
  assign wrap.wideWrap   = wideWrap;
endmodule

// File: rtl/baud_tick_ctrl.sv
module baud_tick_ctrl
  import baud_tick_pkg::*;
#(
  parameter int unsigned SLOW_DIV = 12
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  narrowFast,
  input  logic  doubleRate,
  input  logic  txUseWide,
  input  logic  rxUseWide,
  input  wrap_t wrap,
  output step_t step,
  output logic  txTick,
  output logic  rxTick
);
  localparam int unsigned PW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(SLOW_DIV - 1);

  logic [PW-1:0] preCnt;
  logic          slowPulse;
  logic          halfPhase;
  logic          pairPhase;
  logic          narrowTick;
  logic          wideRun;
  logic [NUM_CH-1:0] chSel;
  logic [NUM_CH-1:0] tickQ;

  // divide-by-SLOW_DIV prescaler for the narrow timer
  assign slowPulse = (preCnt == PRE_LAST);
  always_ff @(posedge clk) begin
    if (rst)            preCnt <= '0;
    else if (slowPulse) preCnt <= '0;
    else                preCnt <= preCnt + 1'b1;
  end

  // divide-by-2 phase for the wide timer
  always_ff @(posedge clk) begin
    if (rst) halfPhase <= 1'b0;
    else     halfPhase <= ~halfPhase;
  end

  assign wideRun         = txUseWide | rxUseWide;
  assign step.narrowStep = narrowFast | slowPulse;
  assign step.wideStep   = halfPhase & wideRun;

  // rate doubler: pass every overflow, or every second one
  always_ff @(posedge clk) begin
    if (rst)                  pairPhase <= 1'b0;
    else if (wrap.narrowWrap) pairPhase <= ~pairPhase;
  end
  assign narrowTick = wrap.narrowWrap & (doubleRate | pairPhase);

  assign chSel[CH_TX] = txUseWide;
  assign chSel[CH_RX] = rxUseWide;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) tickQ[ch] <= 1'b0;
      else     tickQ[ch] <= chSel[ch] ? wrap.wideWrap : narrowTick;
    end
  end

  assign txTick = tickQ[CH_TX];
  assign rxTick = tickQ[CH_RX];
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int unsigned NARROW_W = 8,
  parameter int unsigned WIDE_W   = 16,
  parameter int unsigned SLOW_DIV = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                narrowFast,
  input  logic                doubleRate,
  input  logic                txUseWide,
  input  logic                rxUseWide,
  input  logic [NARROW_W-1:0] narrowReload,
  input  logic [WIDE_W-1:0]   wideReload,
  output logic                txTick,
  output logic                rxTick
);
  step_t               step;
  wrap_t               wrap;
  logic [NARROW_W-1:0] narrowCount;
  logic [WIDE_W-1:0]   wideCount;

  baud_tick_ctrl #(.SLOW_DIV(SLOW_DIV)) u_ctrl (
    .clk(clk), .rst(rst), .narrowFast(narrowFast), .doubleRate(doubleRate),
    .txUseWide(txUseWide), .rxUseWide(rxUseWide), .wrap(wrap), .step(step),
    .txTick(txTick), .rxTick(rxTick)
  );

  baud_tick_dp #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_dp (
    .clk(clk), .rst(rst), .step(step), .narrowReload(narrowReload),
    .wideReload(wideReload), .wrap(wrap), .narrowCount(narrowCount),
    .wideCount(wideCount)
  );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int unsigned NARROW_W = 8,
  parameter int unsigned WIDE_W   = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                narrowFast,
  input logic                txUseWide,
  input logic                rxUseWide,
  input logic                txTick,
  input logic                rxTick,
  input logic [NARROW_W-1:0] narrowCount,
  input logic [WIDE_W-1:0]   wideCount
);
  // R1: the cycle after a reset cycle shows no tick
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!txTick && !rxTick));

  // R7: an unselected wide timer does not move
  a_r7_wide_holds: assert property (@(posedge clk) disable iff (rst)
    (!txUseWide && !rxUseWide) |=> $stable(wideCount));

  // R9: wide-sourced TX tick never lasts two cycles
  a_r9_wide_pulse: assert property (@(posedge clk) disable iff (rst)
    (txTick && $past(txUseWide) && txUseWide) |=> !txTick);

  // R10: equal routing gives identical strobes
  a_r10_same_source: assert property (@(posedge clk) disable iff (rst)
    ($past(txUseWide) == $past(rxUseWide)) |-> (txTick == rxTick));

  // R4: in slow mode the narrow count never moves on two adjacent cycles
  a_r4_slow_spacing: assert property (@(posedge clk) disable iff (rst)
    (!narrowFast && $past(!narrowFast) && (narrowCount != $past(narrowCount)))
    |=> $stable(narrowCount));
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_chk (
  .clk(clk), .rst(rst), .narrowFast(narrowFast), .txUseWide(txUseWide),
  .rxUseWide(rxUseWide), .txTick(txTick), .rxTick(rxTick),
  .narrowCount(narrowCount), .wideCount(wideCount)
);

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
  localparam int PERIOD = 10;
  localparam int NW = 8;
  localparam int WW = 12;
  localparam int WAIT_LIM = 40000;

  typedef struct packed {
    logic          fast;
    logic          dbl;
    logic          txW;
    logic          rxW;
    logic [NW-1:0] r8;
    logic [WW-1:0] r16;
    logic [15:0]   expTx;
    logic [15:0]   expRx;
  } vec_t;

  // wide span is 2^12 = 4096 in this bench
  localparam vec_t VECS [8] = '{
    '{1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 12'd0,    16'd256, 16'd256},
    '{1'b1, 1'b1, 1'b0, 1'b0, 8'hF0, 12'd0,    16'd16,  16'd16 },
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'hF0, 12'd0,    16'd32,  16'd32 },
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'hF8, 12'd0,    16'd96,  16'd96 },
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'hFA, 12'd0,    16'd144, 16'd144},
    '{1'b1, 1'b1, 1'b1, 1'b0, 8'hF0, 12'd4046, 16'd100, 16'd16 },
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'hE0, 12'd4089, 16'd64,  16'd14 },
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'hF0, 12'd4095, 16'd2,   16'd2  }
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic narrowFast = 1'b1, doubleRate = 1'b1, txUseWide = 1'b0, rxUseWide = 1'b0;
  logic [NW-1:0] narrowReload = '0;
  logic [WW-1:0] wideReload = '0;
  logic txTick, rxTick;

  int total = 0, bad = 0;
  int cyc = 0;
  int txLast = 0, rxLast = 0, txPer = 0, rxPer = 0, txCnt = 0, rxCnt = 0;
  int txDouble = 0, rxDouble = 0;
  logic txPrev = 1'b0, rxPrev = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  baud_tick_gen #(.NARROW_W(NW), .WIDE_W(WW)) u0 (
    .clk(clk), .rst(rst), .narrowFast(narrowFast), .doubleRate(doubleRate),
    .txUseWide(txUseWide), .rxUseWide(rxUseWide), .narrowReload(narrowReload),
    .wideReload(wideReload), .txTick(txTick), .rxTick(rxTick)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // tick monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (txTick) begin txPer = cyc - txLast; txLast = cyc; txCnt++; end
    if (rxTick) begin rxPer = cyc - rxLast; rxLast = cyc; rxCnt++; end
    if (txTick && txPrev) txDouble++;
    if (rxTick && rxPrev) rxDouble++;
    txPrev = txTick;
    rxPrev = rxTick;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(output int relCyc);
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    relCyc = cyc;
  endtask

  task automatic waitTx(input int n, input string req);
    int base = txCnt;
    int lim = 0;
    while (txCnt < base + n && lim < WAIT_LIM) begin @(posedge clk); lim++; end
    if (lim >= WAIT_LIM) check(1'b0, req, txCnt - base, n);
  endtask

  task automatic waitRx(input int n, input string req);
    int base = rxCnt;
    int lim = 0;
    while (rxCnt < base + n && lim < WAIT_LIM) begin @(posedge clk); lim++; end
    if (lim >= WAIT_LIM) check(1'b0, req, rxCnt - base, n);
  endtask

  initial begin
    #(PERIOD * 190000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int rel;
    int dTx, dRx, sw;

    // R1: quiet during reset, first tick 256 clocks after release
    narrowFast = 1'b1; doubleRate = 1'b1; narrowReload = 8'hF0;
    @(negedge clk);
    check(!txTick && !rxTick, "R1 ticks low in reset", {txTick, rxTick}, 0);
    doReset(rel);
    waitTx(1, "R1 first tick");
    check(txLast - rel == 256, "R1 first tick delay", txLast - rel, 256);

    // table of configurations: R2 R3 R4 R5 R6 R9 R10
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      narrowFast = VECS[i].fast; doubleRate = VECS[i].dbl;
      txUseWide = VECS[i].txW; rxUseWide = VECS[i].rxW;
      narrowReload = VECS[i].r8; wideReload = VECS[i].r16;
      doReset(rel);
      dTx = txDouble; dRx = rxDouble;
      waitTx(3, "R2-period tx wait");
      waitRx(3, "R6 rx wait");
      check(txPer == int'(VECS[i].expTx), $sformatf("R2/R3/R4/R5 tx period vec%0d", i),
            txPer, int'(VECS[i].expTx));
      check(rxPer == int'(VECS[i].expRx), $sformatf("R6 rx period vec%0d", i),
            rxPer, int'(VECS[i].expRx));
      check(txDouble == dTx && rxDouble == dRx, $sformatf("R9 single-cycle vec%0d", i),
            txDouble + rxDouble - dTx - dRx, 0);
      if (VECS[i].txW == VECS[i].rxW)
        check(txLast == rxLast, $sformatf("R10 coincident vec%0d", i), txLast, rxLast);
    end

    // R7: wide timer idle while unselected
    @(negedge clk);
    narrowFast = 1'b1; doubleRate = 1'b1; txUseWide = 1'b0; rxUseWide = 1'b0;
    narrowReload = 8'h00; wideReload = 12'd4095;
    doReset(rel);
    repeat (3000) @(negedge clk);
    txUseWide = 1'b1;
    sw = cyc;
    waitTx(1, "R7 wait");
    check((txLast - sw) >= 8190 && (txLast - sw) <= 8193, "R7 wide start from zero",
          txLast - sw, 8191);

    // R8: reload change applies at the next rollover
    @(negedge clk);
    txUseWide = 1'b0; narrowReload = 8'hF0;
    doReset(rel);
    waitTx(3, "R8 settle");
    check(txPer == 16, "R8 old period", txPer, 16);
    repeat (3) @(negedge clk);
    narrowReload = 8'hE0;
    waitTx(1, "R8 wait a");
    check(txPer == 16, "R8 interval in progress", txPer, 16);
    waitTx(1, "R8 wait b");
    check(txPer == 32, "R8 new period", txPer, 32);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule